// File: doc/BRIEF.md
# Power-Good Assertion Delay Timer

This block holds back an external power-good output until a programmed time has passed since the internal power-good condition became true. Software writes the delay as a 16-bit word in the L11 linear format, with units of milliseconds. The block turns that word into a number of 200 µs ticks, rounds it to the nearest tick, and limits it to a ceiling of 13.1 s (65500 ticks by default). A read of the register always returns the word as it was written, with no rounding or limiting applied.

Ticks come from one of two single-cycle strobes. When the shared-clock-present flag is high, the shared-clock tick is counted. Otherwise the local oscillator tick is counted. The counter reloads from the register whenever the internal power-good is low. It counts down only while the internal power-good is high. The output is the internal power-good gated by "count reached zero", so it falls in the same cycle that the internal signal falls.

The register port is plain control: a write strobe with data is accepted on every cycle and never stalls. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `pg_delay_timer`

## Requirements
- R1: With `pg_int` held high, `pg_out` rises after exactly N selected ticks, where N is the tick count decoded from the register. The first tick counted is the one on the first clock edge at which `pg_int` is high. N = 0 makes `pg_out` follow `pg_int` in the same cycle.
- R2: The register word is decoded as follows. Bits 15:11 hold a two's-complement exponent e (-16..15). Bits 10:0 hold a two's-complement mantissa m (-1024..1023). The delay in milliseconds is m·2^e.
- R3: N = floor(5·m·2^e + 0.5), which rounds to the nearest 200 µs tick with halves rounded up.
- R4: A mantissa of zero or less gives N = 0.
- R5: N is limited to MAX_TICKS (65500 by default), and the internal count never exceeds MAX_TICKS.
- R6: One cycle after a write, `reg_rd_data` equals the written word exactly, with no decoding applied.
- R7: When `shared_present` is 1, only `shared_tick` advances the count. When it is 0, only `osc_tick` advances it. The count holds on any cycle in which the selected tick is low.
- R8: `pg_out` is never high while `pg_int` is low, and it falls in the same cycle that `pg_int` falls. After a drop, the next rise of `pg_int` waits the full N ticks again.
- R9: A register write made while `pg_int` is high leaves the delay in progress unchanged. The new value applies from the next rise of `pg_int`.
- R10: During and right after reset, `pg_out` is 0 and `reg_rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_int | input | 1 | Internal power-good condition |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 16 | L11 delay word to write (ms) |
| reg_rd_data | output | 16 | Last written word, raw |
| shared_present | input | 1 | Shared clock tick is available |
| shared_tick | input | 1 | One-cycle tick from the shared clock, 200 µs spacing |
| osc_tick | input | 1 | One-cycle tick from the local oscillator, 200 µs spacing |
| pg_out | output | 1 | Delayed external power-good |

## Verification
Two functions can act on the same cycle. A register write can arrive while a delay is counting, and it must not disturb the delay already in progress. The internal power-good can also drop on the same edge on which a tick would decrement the count. The bench starts a 20-tick delay and writes a 5-tick word at tick 5 of that delay. It expects the output on the 20th edge, and then exactly 5 edges after the next rise. It also aborts a delay midway and checks that the output falls at once and that the following rise waits the full count again.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned EXP_W  = 5;
  localparam int unsigned MAN_W  = 11;
  // ticks per millisecond at a 200 us tick
  localparam int unsigned TICKS_PER_MS = 5;

  typedef struct packed {
    logic signed [EXP_W-1:0] exp;
    logic signed [MAN_W-1:0] man;
  } l11_word_t;
endpackage

// File: rtl/pgd_l11_ticks.sv
module pgd_l11_ticks
  import pgd_pkg::*;
#(
  parameter int unsigned MAX_TICKS = 65500,
  parameter int unsigned CNT_W     = $clog2(MAX_TICKS + 1)
) (
  input  l11_word_t        word,
  output logic [CNT_W-1:0] ticks
);
  localparam int unsigned PROD_W = MAN_W + 3;
  localparam int unsigned SHIFT_MAX = 1 << (EXP_W - 1);
  localparam int unsigned WIDE_W = PROD_W + SHIFT_MAX;

  logic [PROD_W-1:0] mag;
  logic [PROD_W-1:0] scaled;
  logic [WIDE_W-1:0] wide;
  logic [WIDE_W-1:0] half;
  logic [WIDE_W-1:0] shifted;
  logic [EXP_W:0]    rshift;

  always_comb begin
    mag = '0;
    if (!word.man[MAN_W-1]) mag = PROD_W'(word.man[MAN_W-2:0]);
    scaled = mag * PROD_W'(TICKS_PER_MS);
    wide   = WIDE_W'(scaled);
    rshift = '0;
    half   = '0;
    if (!word.exp[EXP_W-1]) begin
      shifted = wide << word.exp[EXP_W-2:0];
    end else begin
      rshift  = (EXP_W+1)'(1 << EXP_W) - {1'b0, word.exp};
      half    = WIDE_W'(1) << (rshift - (EXP_W+1)'(1));
      shifted = (wide + half) >> rshift;
    end
    if (shifted > WIDE_W'(MAX_TICKS)) ticks = CNT_W'(MAX_TICKS);
    else                              ticks = shifted[CNT_W-1:0];
  end
endmodule

// File: rtl/pgd_tick_sel.sv
module pgd_tick_sel (
  input  logic shared_present,
  input  logic shared_tick,
  input  logic osc_tick,
  output logic tick
);
  always_comb begin
    if (shared_present) tick = shared_tick;
    else                tick = osc_tick;
  end
endmodule

// File: rtl/pgd_delay_ctr.sv
module pgd_delay_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_int,
  input  logic             tick,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             done
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!pg_int) begin
      cnt <= load_val;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pg_delay_timer.sv
module pg_delay_timer
  import pgd_pkg::*;
#(
  parameter int unsigned MAX_TICKS = 65500,
  localparam int unsigned CNT_W    = $clog2(MAX_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_int,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wr_data,
  output logic [WORD_W-1:0] reg_rd_data,
  input  logic              shared_present,
  input  logic              shared_tick,
  input  logic              osc_tick,
  output logic              pg_out
);
  logic [WORD_W-1:0] delay_word;
  logic [CNT_W-1:0]  delay_ticks;
  logic [CNT_W-1:0]  cnt;
  logic              cnt_done;
  logic              tick;

  always_ff @(posedge clk) begin
    if (!rst_n)         delay_word <= '0;
    else if (reg_wr_en) delay_word <= reg_wr_data;
  end

  assign reg_rd_data = delay_word;

  pgd_l11_ticks #(.MAX_TICKS(MAX_TICKS), .CNT_W(CNT_W)) u_decode (
    .word  (l11_word_t'(delay_word)),
    .ticks (delay_ticks)
  );

  pgd_tick_sel u_tick_sel (
    .shared_present (shared_present),
    .shared_tick    (shared_tick),
    .osc_tick       (osc_tick),
    .tick           (tick)
  );

  pgd_delay_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pg_int   (pg_int),
    .tick     (tick),
    .load_val (delay_ticks),
    .cnt      (cnt),
    .done     (cnt_done)
  );

  assign pg_out = pg_int & cnt_done;
endmodule

// File: rtl/pgd_checker.sv
module pgd_checker #(
  parameter int unsigned MAX_TICKS = 65500,
  parameter int unsigned CNT_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pg_int,
  input logic             pg_out,
  input logic             reg_wr_en,
  input logic [15:0]      reg_wr_data,
  input logic [15:0]      reg_rd_data,
  input logic             shared_present,
  input logic             shared_tick,
  input logic             osc_tick,
  input logic [CNT_W-1:0] cnt
);
  logic sel_tick;
  assign sel_tick = shared_present ? shared_tick : osc_tick;

  AST_OUT_NEEDS_INT: assert property (@(posedge clk) disable iff (!rst_n)
    pg_out |-> pg_int); // R8
  AST_FALL_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_int) |-> !pg_out); // R8
  AST_CNT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_TICKS)); // R5
  AST_RD_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> reg_rd_data == $past(reg_wr_data)); // R6
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pg_int) && !$past(sel_tick)) |-> cnt == $past(cnt)); // R7
  AST_COUNT_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pg_int) |-> cnt <= $past(cnt)); // R1
  AST_WRITE_NO_DISTURB: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pg_int) && $past(reg_wr_en) && !$past(sel_tick)) |-> cnt == $past(cnt)); // R9
endmodule

bind pg_delay_timer pgd_checker #(.MAX_TICKS(MAX_TICKS), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pg_int         (pg_int),
  .pg_out         (pg_out),
  .reg_wr_en      (reg_wr_en),
  .reg_wr_data    (reg_wr_data),
  .reg_rd_data    (reg_rd_data),
  .shared_present (shared_present),
  .shared_tick    (shared_tick),
  .osc_tick       (osc_tick),
  .cnt            (cnt)
);

// File: tb/pg_delay_timer_bench.sv
module pg_delay_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SMALL_MAX  = 300;
  localparam int DFLT_MAX   = 65500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_int = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wr_data = '0;
  logic        shared_present = 1'b1;
  logic        shared_tick = 1'b0;
  logic        osc_tick = 1'b0;
  logic [15:0] rd_small, rd_dflt;
  logic        pg_small, pg_dflt;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pg_delay_timer #(.MAX_TICKS(SMALL_MAX)) u_pg_delay_timer (
    .clk(clk), .rst_n(rst_n), .pg_int(pg_int), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(rd_small),
    .shared_present(shared_present), .shared_tick(shared_tick),
    .osc_tick(osc_tick), .pg_out(pg_small));

  pg_delay_timer u_pg_delay_timer_dflt (
    .clk(clk), .rst_n(rst_n), .pg_int(pg_int), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(rd_dflt),
    .shared_present(shared_present), .shared_tick(shared_tick),
    .osc_tick(osc_tick), .pg_out(pg_dflt));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_ticks(input logic [15:0] w, input int maxv);
    int e, m, t;
    real v;
    e = int'(w[15:11]); if (e > 15) e -= 32;
    m = int'(w[10:0]);  if (m > 1023) m -= 2048;
    if (m <= 0) return 0;
    v = 5.0 * m;
    if (e >= 0) for (int i = 0; i < e; i++) v = v * 2.0;
    else        for (int i = 0; i < -e; i++) v = v / 2.0;
    t = int'($floor(v + 0.5));
    if (t > maxv) t = maxv;
    return t;
  endfunction

  task automatic write_reg(input logic [15:0] w);
    @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = w;
    @(negedge clk); reg_wr_en = 1'b0;
    #1 check(rd_small == w, "R6 readback", int'(rd_small), int'(w));
  endtask

  task automatic set_ticks(input int c, input int per_sh, input int per_osc);
    shared_tick = ((c % per_sh) == 0);
    osc_tick    = ((c % per_osc) == 0);
  endtask

  // raise pg_int and count edges until the chosen output rises
  task automatic measure(input int per_sh, input int per_osc, input int limit,
                         input bit dflt, output int cyc);
    cyc = -1;
    @(negedge clk);
    set_ticks(1, per_sh, per_osc);
    pg_int = 1'b1;
    #1;
    if ((dflt ? pg_dflt : pg_small) == 1'b1) begin cyc = 0; return; end
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk);
      set_ticks(c + 1, per_sh, per_osc);
      #1;
      if ((dflt ? pg_dflt : pg_small) == 1'b1) begin cyc = c; return; end
    end
  endtask

  task automatic drop_pg();
    @(negedge clk);
    pg_int = 1'b0;
    #1 check(pg_small == 1'b0, "R8 same-cycle fall", int'(pg_small), 0);
    @(negedge clk);
  endtask

  initial begin
    int cyc, exp_n, first;
    int mans[7] = '{0, 1, 3, 7, 37, 1023, -5};
    string tag;
    logic [15:0] w;

    repeat (3) @(negedge clk);
    check(pg_small == 1'b0, "R10 pg_out in reset", int'(pg_small), 0);
    @(negedge clk); rst_n = 1'b1;
    #1 check(pg_small == 1'b0, "R10 pg_out after reset", int'(pg_small), 0);
    check(rd_small == 16'h0, "R10 readback after reset", int'(rd_small), 0);

    // sweep over all exponents and a spread of mantissas, tick on every cycle
    shared_present = 1'b1;
    for (int e = -16; e <= 15; e++) begin
      foreach (mans[i]) begin
        w = {5'(e), 11'(mans[i])};
        exp_n = expect_ticks(w, SMALL_MAX);
        write_reg(w);
        @(negedge clk);
        measure(1, 1, SMALL_MAX + 5, 1'b0, cyc);
        if (mans[i] <= 0)           tag = "R4 R1 non-positive";
        else if (exp_n == SMALL_MAX) tag = "R5 R1 clamp";
        else if (e < 0)             tag = "R3 R1 rounding";
        else                        tag = "R2 R1 decode";
        check(cyc == exp_n, tag, cyc, exp_n);
        drop_pg();
      end
    end

    // R7: tick source selection, 10-tick delay (m=2, e=0)
    write_reg({5'd0, 11'd2});
    shared_present = 1'b1;
    measure(2, 3, 100, 1'b0, cyc);
    check(cyc == 20, "R7 shared tick selected", cyc, 20);
    drop_pg();
    shared_present = 1'b0;
    measure(2, 3, 100, 1'b0, cyc);
    check(cyc == 30, "R7 oscillator tick selected", cyc, 30);
    drop_pg();
    shared_present = 1'b1;

    // R8: abort midway, output low, then full delay again (20 ticks)
    write_reg({5'd0, 11'd4});
    @(negedge clk);
    shared_tick = 1'b1; pg_int = 1'b1;
    repeat (10) @(negedge clk);
    #1 check(pg_small == 1'b0, "R8 still delaying", int'(pg_small), 0);
    drop_pg();
    measure(1, 1, 100, 1'b0, cyc);
    check(cyc == 20, "R8 full delay after abort", cyc, 20);
    drop_pg();

    // R9: write a 5-tick word during a 20-tick delay
    first = -1;
    @(negedge clk);
    shared_tick = 1'b1; pg_int = 1'b1;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      if (c == 5) begin reg_wr_en = 1'b1; reg_wr_data = {5'd0, 11'd1}; end
      else reg_wr_en = 1'b0;
      #1;
      if (pg_small && first < 0) first = c;
    end
    check(first == 20, "R9 delay in progress unchanged", first, 20);
    check(rd_small == {5'd0, 11'd1}, "R9 R6 readback after write", int'(rd_small), 16'h0001);
    drop_pg();
    measure(1, 1, 100, 1'b0, cyc);
    check(cyc == 5, "R9 new value on next rise", cyc, 5);
    drop_pg();

    // R5: default ceiling, 65500 ticks; raw word readback keeps the unclamped value
    w = {5'd15, 11'd1023};
    write_reg(w);
    check(rd_dflt == w, "R5 R6 raw word, not clamped", int'(rd_dflt), int'(w));
    @(negedge clk);
    measure(1, 1, DFLT_MAX + 10, 1'b1, cyc);
    check(cyc == DFLT_MAX, "R5 default ceiling", cyc, DFLT_MAX);
    drop_pg();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule